// File: doc/BRIEF.md
# SDRAM Command Legality Tracker

This block sits beside an SDRAM command bus and samples it on every rising clock edge. It turns the clock-enable, select and strobe pins into a named command. It keeps the open or closed state of each bank and runs a set of down-counters for each bank's timing windows. Each command is checked against the bank state and against those windows, and the block reports the command, a flag and a reason code one cycle later.

A command that fails a check is reported and then dropped: it does not change the bank state, the counters or the stored mode word. A protocol monitor, a memory-controller self-check or a simulation scoreboard can use the block to flag command streams that break the timing rules or the bank-state rules. It also gives the mode word and the burst length in force, which set how long a write burst lasts and when an auto-precharge completes.

Top module: `sdcmd_tracker`

## Requirements
- R1: The command is decoded from the pins as follows. Clock enable low gives code 9 (inhibit). Otherwise, select high gives code 0 (deselect). Otherwise {RAS#,CAS#,WE#} gives the command: 111 is NOP (code 1), 110 is burst stop (2), 101 is READ (3), 100 is WRITE (4), 011 is ACTIVE (5), 010 is PRECHARGE (6), 001 is REFRESH (7) and 000 is MODE SET (8).
- R2: `cmd_o`, `illegal_o` and `reason_o` are registered and show the command sampled at the previous edge. Reset gives code 0, no flag and reason 0. The checks are applied in this order, and the first one that fails gives the reason: the refresh window (rule R10), then the bank-state rules, then the timing windows. Reasons 1 to 3 are state errors and reasons 8 and above are timing errors.
- R3: A legal ACTIVE opens the bank given by the bank address, and `bank_open_o` shows it after the same edge. ACTIVE to a bank that is already open is illegal with reason 2.
- R4: READ or WRITE to a closed bank is illegal with reason 1.
- R5: READ or WRITE to a bank is illegal with reason 9 until 3 cycles after that bank's ACTIVE.
- R6: ACTIVE to a bank is illegal with reason 10 until 3 cycles after that bank was precharged.
- R7: ACTIVE is illegal with reason 11 within 2 cycles of the previous legal ACTIVE.
- R8: PRECHARGE of an open bank is illegal with reason 12 until 7 cycles after its ACTIVE. PRECHARGE of a closed bank is legal and has no effect.
- R9: PRECHARGE with address bit 10 high closes every open bank. With bit 10 low it closes only the addressed bank.
- R10: REFRESH and MODE SET are illegal with reason 3 while any bank is open, and with reason 10 while any bank is still inside its precharge window. After a legal REFRESH, every command other than deselect, NOP and inhibit is illegal with reason 8 for the next 9 cycles.
- R11: A legal MODE SET stores the 12 address bits in `mode_o`. Bits 2:0 give the burst length: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8, 111 gives a full page of 256, and any other code gives 1. When bit 9 is set, a write burst is 1 beat long.
- R12: A write burst starts with one data beat in the WRITE cycle and continues for the write burst length. A legal READ, WRITE or burst stop ends it, and so does a legal PRECHARGE of the bank being written. PRECHARGE of that bank is illegal with reason 13 until 2 cycles after the last beat.
- R13: READ or WRITE with address bit 10 high closes the bank after the same edge. A new ACTIVE to that bank becomes legal a set number of cycles after the command. For a read the delay is the burst length plus 3. For a write it is the write burst length plus 2 plus 3.
- R14: An illegal command changes neither `bank_open_o` nor `mode_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke_i | input | 1 | Clock enable pin |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| addr_i | input | 12 | Address bus |
| ba_i | input | 2 | Bank address |
| cmd_o | output | 4 | Decoded command code of the previous cycle |
| illegal_o | output | 1 | Previous command was illegal |
| reason_o | output | 4 | Reason code for the flag, 0 when legal |
| bank_open_o | output | 4 | One bit per bank, set while the bank is open |
| mode_o | output | 12 | Stored mode word |

## Verification
The hardest cases to reach are the ones where a PRECHARGE is refused only because of the write-recovery window. That needs a bank that has passed its minimum active time, a mode word that sets the write burst length, and a write burst whose last beat is placed exactly, either by its natural end or by a burst stop. The directed stimulus first programs the single-beat write mode and then a burst of four. In each case it waits out the active time before the write and issues PRECHARGE one cycle too early and then exactly on time. The auto-precharge delays are measured the same way, with ACTIVE tried one cycle before the computed release and then on it.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [3:0] {
    CMD_DESEL = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_BST   = 4'd2,
    CMD_READ  = 4'd3,
    CMD_WRITE = 4'd4,
    CMD_ACT   = 4'd5,
    CMD_PRE   = 4'd6,
    CMD_REF   = 4'd7,
    CMD_MRS   = 4'd8,
    CMD_INH   = 4'd9
  } cmd_e;

  // bit 3 set marks a timing-window error, clear marks a state error
  typedef enum logic [3:0] {
    RSN_NONE      = 4'd0,
    RSN_BANK_SHUT = 4'd1,
    RSN_BANK_BUSY = 4'd2,
    RSN_NOT_IDLE  = 4'd3,
    RSN_TRC       = 4'd8,
    RSN_TRCD      = 4'd9,
    RSN_TRP       = 4'd10,
    RSN_TRRD      = 4'd11,
    RSN_TRAS      = 4'd12,
    RSN_TDPL      = 4'd13
  } rsn_e;

  function automatic int unsigned burst_beats(input logic [2:0] code,
                                              input int unsigned page);
    case (code)
      3'b001:  return 2;
      3'b010:  return 4;
      3'b011:  return 8;
      3'b111:  return page;
      default: return 1;
    endcase
  endfunction

  function automatic int unsigned write_beats(input logic [2:0] code,
                                              input logic single,
                                              input int unsigned page);
    return single ? 1 : burst_beats(code, page);
  endfunction

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
(
  input  logic cke_i,
  input  logic cs_n_i,
  input  logic ras_n_i,
  input  logic cas_n_i,
  input  logic we_n_i,
  output cmd_e cmd_o
);

  always_comb begin
    if (!cke_i) begin
      cmd_o = CMD_INH;
    end else if (cs_n_i) begin
      cmd_o = CMD_DESEL;
    end else begin
      case ({ras_n_i, cas_n_i, we_n_i})
        3'b111:  cmd_o = CMD_NOP;
        3'b110:  cmd_o = CMD_BST;
        3'b101:  cmd_o = CMD_READ;
        3'b100:  cmd_o = CMD_WRITE;
        3'b011:  cmd_o = CMD_ACT;
        3'b010:  cmd_o = CMD_PRE;
        3'b001:  cmd_o = CMD_REF;
        default: cmd_o = CMD_MRS;
      endcase
    end
  end

endmodule

// File: rtl/sdcmd_bank.sv
module sdcmd_bank #(
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RAS = 7,
  parameter int T_DPL = 2,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             ap_i,
  input  logic [CNT_W-1:0] ap_wait_i,
  input  logic             beat_i,
  output logic             open_o,
  output logic             rcd_ok_o,
  output logic             rp_ok_o,
  output logic             ras_ok_o,
  output logic             dpl_ok_o
);

  logic [CNT_W-1:0] rcd_cnt, rp_cnt, ras_cnt, dpl_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_o  <= 1'b0;
      rcd_cnt <= '0;
      rp_cnt  <= '0;
      ras_cnt <= '0;
      dpl_cnt <= '0;
    end else begin
      if (act_i) begin
        open_o  <= 1'b1;
        rcd_cnt <= CNT_W'(T_RCD - 1);
        ras_cnt <= CNT_W'(T_RAS - 1);
      end else begin
        if (rcd_cnt != '0) rcd_cnt <= rcd_cnt - 1'b1;
        if (ras_cnt != '0) ras_cnt <= ras_cnt - 1'b1;
      end

      if (pre_i) begin
        open_o <= 1'b0;
        rp_cnt <= CNT_W'(T_RP - 1);
      end else if (ap_i) begin
        open_o <= 1'b0;
        rp_cnt <= ap_wait_i;
      end else if (rp_cnt != '0) begin
        rp_cnt <= rp_cnt - 1'b1;
      end

      if (beat_i)              dpl_cnt <= CNT_W'(T_DPL - 1);
      else if (dpl_cnt != '0)  dpl_cnt <= dpl_cnt - 1'b1;
    end
  end

  assign rcd_ok_o = (rcd_cnt == '0);
  assign rp_ok_o  = (rp_cnt  == '0);
  assign ras_ok_o = (ras_cnt == '0);
  assign dpl_ok_o = (dpl_cnt == '0);

  // R3
  act_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |=> open_o);

  // R9
  close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_i || ap_i) |=> !open_o);

  // R5
  rcd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |=> ((T_RCD < 2) || !rcd_ok_o));

  // R6
  rp_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_i |=> ((T_RP < 2) || !rp_ok_o));

endmodule

// File: rtl/sdcmd_rules.sv
module sdcmd_rules
  import sdcmd_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int BA_W  = 2
) (
  input  cmd_e             cmd_i,
  input  logic [BA_W-1:0]  ba_i,
  input  logic             all_i,
  input  logic [NBANK-1:0] open_i,
  input  logic [NBANK-1:0] rcd_ok_i,
  input  logic [NBANK-1:0] rp_ok_i,
  input  logic [NBANK-1:0] ras_ok_i,
  input  logic [NBANK-1:0] dpl_ok_i,
  input  logic             rrd_ok_i,
  input  logic             rc_ok_i,
  output logic             bad_o,
  output rsn_e             rsn_o
);

  logic [NBANK-1:0] tgt;

  always_comb begin
    tgt   = all_i ? {NBANK{1'b1}} : (NBANK'(1) << ba_i);
    rsn_o = RSN_NONE;
    if (cmd_i inside {CMD_DESEL, CMD_NOP, CMD_INH}) begin
      rsn_o = RSN_NONE;
    end else if (!rc_ok_i) begin
      rsn_o = RSN_TRC;
    end else begin
      case (cmd_i)
        CMD_READ, CMD_WRITE: begin
          if (!open_i[ba_i])         rsn_o = RSN_BANK_SHUT;
          else if (!rcd_ok_i[ba_i])  rsn_o = RSN_TRCD;
        end
        CMD_ACT: begin
          if (open_i[ba_i])          rsn_o = RSN_BANK_BUSY;
          else if (!rp_ok_i[ba_i])   rsn_o = RSN_TRP;
          else if (!rrd_ok_i)        rsn_o = RSN_TRRD;
        end
        CMD_PRE: begin
          if (|(tgt & open_i & ~ras_ok_i))       rsn_o = RSN_TRAS;
          else if (|(tgt & open_i & ~dpl_ok_i))  rsn_o = RSN_TDPL;
        end
        CMD_REF, CMD_MRS: begin
          if (|open_i)               rsn_o = RSN_NOT_IDLE;
          else if (!(&rp_ok_i))      rsn_o = RSN_TRP;
        end
        default: rsn_o = RSN_NONE;
      endcase
    end
    bad_o = (rsn_o != RSN_NONE);
  end

endmodule

// File: rtl/sdcmd_tracker.sv
module sdcmd_tracker
  import sdcmd_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int ADDR_W = 12,
  parameter int COL_W  = 8,
  parameter int AP_BIT = 10,
  parameter int SW_BIT = 9,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 3,
  parameter int T_RRD  = 2,
  parameter int T_RAS  = 7,
  parameter int T_RC   = 10,
  parameter int T_DPL  = 2,
  localparam int BA_W  = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_i,
  input  logic              cs_n_i,
  input  logic              ras_n_i,
  input  logic              cas_n_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BA_W-1:0]   ba_i,
  output logic [3:0]        cmd_o,
  output logic              illegal_o,
  output logic [3:0]        reason_o,
  output logic [NBANK-1:0]  bank_open_o,
  output logic [ADDR_W-1:0] mode_o
);

  localparam int PAGE  = 2 ** COL_W;
  localparam int CNT_W = $clog2(PAGE + T_DPL + T_RP + T_RC + T_RAS + T_RCD + 1) + 1;

  cmd_e             cmd;
  rsn_e             rsn;
  logic             cmd_bad;
  logic [NBANK-1:0] open_v, rcd_ok, rp_ok, ras_ok, dpl_ok;
  logic [CNT_W-1:0] rrd_cnt, rc_cnt;
  logic             rrd_ok, rc_ok;
  logic [ADDR_W-1:0] mode_q;

  sdcmd_decode u_decode (
    .cke_i   (cke_i),
    .cs_n_i  (cs_n_i),
    .ras_n_i (ras_n_i),
    .cas_n_i (cas_n_i),
    .we_n_i  (we_n_i),
    .cmd_o   (cmd)
  );

  assign rrd_ok = (rrd_cnt == '0);
  assign rc_ok  = (rc_cnt  == '0);

  sdcmd_rules #(.NBANK(NBANK), .BA_W(BA_W)) u_rules (
    .cmd_i    (cmd),
    .ba_i     (ba_i),
    .all_i    (addr_i[AP_BIT]),
    .open_i   (open_v),
    .rcd_ok_i (rcd_ok),
    .rp_ok_i  (rp_ok),
    .ras_ok_i (ras_ok),
    .dpl_ok_i (dpl_ok),
    .rrd_ok_i (rrd_ok),
    .rc_ok_i  (rc_ok),
    .bad_o    (cmd_bad),
    .rsn_o    (rsn)
  );

  // named events for the assertions and the bank slices
  logic act_go, pre_go, rd_go, wr_go, rw_go, ref_go, mrs_go, bst_go;
  assign act_go = (cmd == CMD_ACT)   && !cmd_bad;
  assign pre_go = (cmd == CMD_PRE)   && !cmd_bad;
  assign rd_go  = (cmd == CMD_READ)  && !cmd_bad;
  assign wr_go  = (cmd == CMD_WRITE) && !cmd_bad;
  assign rw_go  = rd_go || wr_go;
  assign ref_go = (cmd == CMD_REF)   && !cmd_bad;
  assign mrs_go = (cmd == CMD_MRS)   && !cmd_bad;
  assign bst_go = (cmd == CMD_BST)   && !cmd_bad;

  logic             ap_req;
  logic [NBANK-1:0] ba_hot, pre_tgt;
  assign ap_req  = addr_i[AP_BIT];
  assign ba_hot  = NBANK'(1) << ba_i;
  assign pre_tgt = ap_req ? {NBANK{1'b1}} : ba_hot;

  // burst lengths from the stored mode word
  logic [CNT_W-1:0] rd_bl, wr_bl, ap_wait;
  assign rd_bl   = CNT_W'(burst_beats(mode_q[2:0], PAGE));
  assign wr_bl   = CNT_W'(write_beats(mode_q[2:0], mode_q[SW_BIT], PAGE));
  assign ap_wait = wr_go ? CNT_W'(wr_bl + CNT_W'(T_DPL + T_RP - 1))
                         : CNT_W'(rd_bl + CNT_W'(T_RP - 1));

  // write burst tracker: beats left after the current cycle
  logic [CNT_W-1:0] wr_left;
  logic [BA_W-1:0]  wr_bank;
  logic             wr_term, beat_now;
  logic [NBANK-1:0] beat_v;

  assign wr_term  = rd_go || wr_go || bst_go || (pre_go && pre_tgt[wr_bank]);
  assign beat_now = (wr_left != '0) && !wr_term;
  assign beat_v   = wr_go ? ba_hot : (beat_now ? (NBANK'(1) << wr_bank) : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_left <= '0;
      wr_bank <= '0;
    end else if (wr_go) begin
      wr_left <= wr_bl - 1'b1;
      wr_bank <= ba_i;
    end else if (beat_now) begin
      wr_left <= wr_left - 1'b1;
    end else if (wr_term) begin
      wr_left <= '0;
    end
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    sdcmd_bank #(
      .T_RCD (T_RCD),
      .T_RP  (T_RP),
      .T_RAS (T_RAS),
      .T_DPL (T_DPL),
      .CNT_W (CNT_W)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_i     (act_go && ba_hot[g]),
      .pre_i     (pre_go && pre_tgt[g]),
      .ap_i      (rw_go && ap_req && ba_hot[g]),
      .ap_wait_i (ap_wait),
      .beat_i    (beat_v[g]),
      .open_o    (open_v[g]),
      .rcd_ok_o  (rcd_ok[g]),
      .rp_ok_o   (rp_ok[g]),
      .ras_ok_o  (ras_ok[g]),
      .dpl_ok_o  (dpl_ok[g])
    );
  end

  // shared windows: ACTIVE spacing and refresh cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrd_cnt <= '0;
      rc_cnt  <= '0;
      mode_q  <= '0;
    end else begin
      if (act_go)              rrd_cnt <= CNT_W'(T_RRD - 1);
      else if (rrd_cnt != '0)  rrd_cnt <= rrd_cnt - 1'b1;
      if (ref_go)              rc_cnt  <= CNT_W'(T_RC - 1);
      else if (rc_cnt != '0)   rc_cnt  <= rc_cnt - 1'b1;
      if (mrs_go)              mode_q  <= addr_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_o     <= CMD_DESEL;
      illegal_o <= 1'b0;
      reason_o  <= RSN_NONE;
    end else begin
      cmd_o     <= cmd;
      illegal_o <= cmd_bad;
      reason_o  <= rsn;
    end
  end

  assign bank_open_o = open_v;
  assign mode_o      = mode_q;

  // R14
  illegal_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_bad |=> ($stable(open_v) && $stable(mode_q)));

  // R2
  flag_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (reason_o != 4'd0));

  // R10
  ref_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_go |=> ((T_RC < 2) || !rc_ok));

  // R7
  rrd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_go |=> ((T_RRD < 2) || !rrd_ok));

  // R11
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_go |=> (mode_q == $past(addr_i)));

  // R12
  dpl_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|beat_v) |=> ((T_DPL < 2) || (dpl_ok != {NBANK{1'b1}})));

endmodule

// File: tb/sdcmd_tracker_tb.sv
module sdcmd_tracker_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cke, cs_n, ras_n, cas_n, we_n;
  logic [11:0] addr;
  logic [1:0]  ba;
  logic [3:0]  cmd_o, reason_o, bank_open_o;
  logic        illegal_o;
  logic [11:0] mode_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // command codes and reason codes as stated in R1 and R2..R13
  localparam int C_DESEL = 0, C_NOP = 1, C_BST = 2, C_RD = 3, C_WR = 4,
                 C_ACT = 5, C_PRE = 6, C_REF = 7, C_MRS = 8, C_INH = 9;
  localparam int R_OK = 0, R_SHUT = 1, R_BUSY = 2, R_NIDLE = 3, R_RC = 8,
                 R_RCD = 9, R_RP = 10, R_RRD = 11, R_RAS = 12, R_DPL = 13;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdcmd_tracker dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cke_i       (cke),
    .cs_n_i      (cs_n),
    .ras_n_i     (ras_n),
    .cas_n_i     (cas_n),
    .we_n_i      (we_n),
    .addr_i      (addr),
    .ba_i        (ba),
    .cmd_o       (cmd_o),
    .illegal_o   (illegal_o),
    .reason_o    (reason_o),
    .bank_open_o (bank_open_o),
    .mode_o      (mode_o)
  );

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input int c, input int b, input logic [11:0] a);
    @(negedge clk);
    cke = 1'b1; cs_n = 1'b0; ba = 2'(b); addr = a;
    {ras_n, cas_n, we_n} = 3'b111;
    case (c)
      C_DESEL: cs_n = 1'b1;
      C_BST:   {ras_n, cas_n, we_n} = 3'b110;
      C_RD:    {ras_n, cas_n, we_n} = 3'b101;
      C_WR:    {ras_n, cas_n, we_n} = 3'b100;
      C_ACT:   {ras_n, cas_n, we_n} = 3'b011;
      C_PRE:   {ras_n, cas_n, we_n} = 3'b010;
      C_REF:   {ras_n, cas_n, we_n} = 3'b001;
      C_MRS:   {ras_n, cas_n, we_n} = 3'b000;
      C_INH:   begin cke = 1'b0; {ras_n, cas_n, we_n} = 3'b011; end
      default: ;
    endcase
    @(posedge clk);
    #1;
  endtask

  // send one command and check the registered verdict
  task automatic issue(input string req, input int c, input int b,
                       input logic [11:0] a, input int rsn);
    send(c, b, a);
    check(req, "cmd", int'(cmd_o), c);
    check(req, "illegal", int'(illegal_o), (rsn != R_OK) ? 1 : 0);
    check(req, "reason", int'(reason_o), rsn);
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) send(C_NOP, 0, 12'h000);
  endtask

  task automatic t_reset;
    check("R2", "reset cmd", int'(cmd_o), C_DESEL);
    check("R2", "reset flag", int'(illegal_o), 0);
    check("R2", "reset reason", int'(reason_o), R_OK);
    check("R3", "reset banks", int'(bank_open_o), 0);
    check("R11", "reset mode", int'(mode_o), 0);
  endtask

  task automatic t_decode;
    issue("R1", C_DESEL, 0, 12'h000, R_OK);
    issue("R1", C_NOP, 1, 12'h000, R_OK);
    issue("R1", C_BST, 2, 12'h000, R_OK);
    issue("R1", C_INH, 0, 12'h000, R_OK);
    check("R1", "inhibit leaves banks", int'(bank_open_o), 0);
  endtask

  task automatic t_idle_rw;
    issue("R4", C_RD, 2, 12'h000, R_SHUT);
    issue("R4", C_WR, 2, 12'h000, R_SHUT);
    check("R14", "banks after illegal rw", int'(bank_open_o), 0);
  endtask

  task automatic t_act_rcd;
    nops(12);
    issue("R3", C_ACT, 0, 12'h000, R_OK);
    check("R3", "bank0 open", int'(bank_open_o), 4'b0001);
    issue("R5", C_RD, 0, 12'h000, R_RCD);
    issue("R5", C_WR, 0, 12'h000, R_RCD);
    issue("R5", C_RD, 0, 12'h000, R_OK);
    issue("R3", C_ACT, 0, 12'h000, R_BUSY);
    check("R14", "banks after busy act", int'(bank_open_o), 4'b0001);
    nops(2);
    issue("R8", C_PRE, 0, 12'h000, R_OK);
    check("R9", "bank0 closed", int'(bank_open_o), 0);
  endtask

  task automatic t_windows;
    nops(12);
    issue("R7", C_ACT, 1, 12'h000, R_OK);
    issue("R7", C_ACT, 2, 12'h000, R_RRD);
    issue("R7", C_ACT, 2, 12'h000, R_OK);
    issue("R8", C_PRE, 1, 12'h000, R_RAS);
    check("R14", "banks after early pre", int'(bank_open_o), 4'b0110);
    nops(3);
    issue("R8", C_PRE, 1, 12'h000, R_OK);
    check("R9", "single close", int'(bank_open_o), 4'b0100);
    issue("R6", C_ACT, 1, 12'h000, R_RP);
    issue("R6", C_ACT, 1, 12'h000, R_RP);
    issue("R6", C_ACT, 1, 12'h000, R_OK);
    issue("R8", C_PRE, 0, 12'h000, R_OK);
    check("R8", "closed bank pre no effect", int'(bank_open_o), 4'b0110);
    issue("R10", C_REF, 0, 12'h000, R_NIDLE);
    issue("R10", C_MRS, 0, 12'h232, R_NIDLE);
    check("R14", "mode after illegal set", int'(mode_o), 0);
    issue("R8", C_PRE, 0, 12'h400, R_RAS);
    nops(2);
    issue("R9", C_PRE, 0, 12'h400, R_OK);
    check("R9", "all closed", int'(bank_open_o), 0);
    issue("R10", C_REF, 0, 12'h000, R_RP);
    nops(1);
    issue("R10", C_REF, 0, 12'h000, R_OK);
    issue("R2", C_RD, 0, 12'h000, R_RC);
    issue("R10", C_INH, 0, 12'h000, R_OK);
    nops(6);
    issue("R10", C_MRS, 0, 12'h232, R_RC);
    issue("R11", C_MRS, 0, 12'h232, R_OK);
    check("R11", "mode stored", int'(mode_o), 12'h232);
  endtask

  task automatic t_dpl_single;
    nops(12);
    issue("R12", C_ACT, 0, 12'h000, R_OK);
    nops(6);
    issue("R11", C_WR, 0, 12'h000, R_OK);
    issue("R11", C_PRE, 0, 12'h000, R_DPL);
    issue("R11", C_PRE, 0, 12'h000, R_OK);
  endtask

  task automatic t_dpl_burst;
    nops(4);
    issue("R11", C_MRS, 0, 12'h022, R_OK);
    check("R11", "mode burst4", int'(mode_o), 12'h022);
    issue("R12", C_ACT, 0, 12'h000, R_OK);
    nops(6);
    issue("R12", C_WR, 0, 12'h000, R_OK);
    nops(1);
    issue("R12", C_PRE, 0, 12'h000, R_DPL);
    nops(1);
    issue("R12", C_PRE, 0, 12'h000, R_DPL);
    issue("R12", C_PRE, 0, 12'h000, R_OK);
  endtask

  task automatic t_bst;
    nops(12);
    issue("R12", C_ACT, 0, 12'h000, R_OK);
    nops(6);
    issue("R12", C_WR, 0, 12'h000, R_OK);
    issue("R12", C_BST, 0, 12'h000, R_OK);
    issue("R12", C_PRE, 0, 12'h000, R_OK);
  endtask

  task automatic t_autopre;
    nops(12);
    issue("R13", C_ACT, 3, 12'h000, R_OK);
    nops(2);
    issue("R13", C_RD, 3, 12'h400, R_OK);
    check("R13", "read ap closes", int'(bank_open_o), 0);
    nops(5);
    issue("R13", C_ACT, 3, 12'h000, R_RP);
    issue("R13", C_ACT, 3, 12'h000, R_OK);
    nops(2);
    issue("R13", C_WR, 3, 12'h400, R_OK);
    check("R13", "write ap closes", int'(bank_open_o), 0);
    nops(7);
    issue("R13", C_ACT, 3, 12'h000, R_RP);
    issue("R13", C_ACT, 3, 12'h000, R_OK);
    nops(6);
    issue("R9", C_PRE, 3, 12'h000, R_OK);
    check("R9", "bank3 closed", int'(bank_open_o), 0);
  endtask

  initial begin
    rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1;
    we_n = 1'b1; addr = '0; ba = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    t_reset();
    t_decode();
    t_idle_rw();
    t_act_rcd();
    t_windows();
    t_dpl_single();
    t_dpl_burst();
    t_bst();
    t_autopre();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule